// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block combines a byte-wide scratch RAM with a calendar clock on one synchronous memory port. The address space is 13 bits wide. The eight highest byte addresses hold the clock registers. Every lower address reaches the RAM. The bus uses active-low chip enable, write enable and output enable. The enables are sampled on the rising clock edge, so the block sits behind any on-chip master that drives those strobes from logic.

The clock keeps seconds, minutes, 24-hour hours, day of week, date, month and two-digit year, all in packed BCD. It advances on a one-clock-wide pulse that arrives once per second. Date rollover follows the length of the month, with a leap-year February. Control bits sit inside the time bytes and do the following:

- stop counting;
- toggle a test output on each tick;
- freeze a coherent snapshot for reading;
- hold the counters while software stages a new time. The staged time is loaded when the hold is released.

Top module: `bcd_rtc_mem`

## Requirements
- R1: After reset the clock reads as control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01 and year 0x00. The data-valid output and the square-wave output are both 0.
- R2: The register fields are selected by address bits 2:0 when bits 12:3 are all ones. The mapping is 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Every other address is a RAM byte, indexed by its low RAM_AW bits, so the RAM repeats every 2**RAM_AW bytes. A byte written there reads back unchanged.
- R3: A write happens once, at the first rising edge where chip enable and write enable are both low. That is the edge where the later of the two goes low. Data is taken from that edge. Holding both low longer adds no further writes. Raising write enable and lowering it again while chip enable stays low makes a new write.
- R4: Control bit 7 is the hold bit. Setting it copies the counters to a staging set and stops their advance. While it is 1, time writes go to the staging set and reads return the staging set. Clearing it loads the staging set into the counters. With the hold bit at 0, a time write goes straight into the counter.
- R5: Each tick increments the seconds. The counters roll over as BCD with carry: seconds and minutes 59→00, hours 23→00, month 12→01, year 99→00.
- R6: The date rolls to 01 after the last day of the month, which carries into the month. April, June, September and November have 30 days. February has 29 days when the BCD year is a multiple of 4, and 28 days otherwise. All other months have 31 days.
- R7: The day of week advances at each midnight and wraps from 07 to 01.
- R8: Seconds bit 7 is the stop bit. While it is 1, ticks change no counter. It reads back in seconds bit 7.
- R9: Control bit 6 is the freeze bit. Setting it captures the counters. While it is 1, reads return the captured values and the counters keep running. Clearing it shows the live counters again.
- R10: Unused bits read as 0 whatever was written to them. These are control 5:0, minutes 7, hours 7:6, day 7 and 5:3, date 7:6, and month 7:5.
- R11: Day-of-week bit 6 is the test bit. While it is 1 and the stop bit is 0, the square-wave output toggles on every tick. At all other times it holds its value.
- R12: A read needs chip enable low, output enable low and write enable high. Its data and a high data-valid output appear one cycle later. A low write enable, or a high output enable, keeps data-valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data valid, drive enable for the data bus |
| sqw | output | 1 | Test square wave |

## Verification
A write takes effect at the rising edge that first sees both enables low. Read data and data-valid are registered once, so they are due one edge after the address is presented. A tick changes the counters and the square wave at the edge where it is sampled. The driver presents every stimulus on a falling edge. The monitor pops the expected byte from the scoreboard at the falling edge after a read, when data-valid is high. Direct checks of the square wave and of data-valid are likewise taken at the falling edge after the stimulus edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } time_t;

    typedef enum logic [2:0] {
        F_CTL  = 3'd0,
        F_SEC  = 3'd1,
        F_MIN  = 3'd2,
        F_HOUR = 3'd3,
        F_DOW  = 3'd4,
        F_DATE = 3'd5,
        F_MON  = 3'd6,
        F_YEAR = 3'd7
    } fld_e;

    localparam time_t RESET_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                     hr: 8'h00, min: 8'h00, sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
    endfunction

    function automatic logic is_leap(input logic [7:0] y);
        logic [7:0] b;
        b = {4'b0, y[7:4]} * 8'd10 + {4'b0, y[3:0]};
        return b[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // One-second advance with full BCD carry chain
    function automatic time_t advance(input time_t t);
        time_t n;
        n = t;
        if (t.sec >= 8'h59) begin
            n.sec = 8'h00;
            if (t.min >= 8'h59) begin
                n.min = 8'h00;
                if (t.hr >= 8'h23) begin
                    n.hr  = 8'h00;
                    n.dow = (t.dow >= 8'h07) ? 8'h01 : bcd_inc(t.dow);
                    if (t.date >= month_len(t.mon, t.yr)) begin
                        n.date = 8'h01;
                        if (t.mon >= 8'h12) begin
                            n.mon = 8'h01;
                            n.yr  = (t.yr >= 8'h99) ? 8'h00 : bcd_inc(t.yr);
                        end else begin
                            n.mon = bcd_inc(t.mon);
                        end
                    end else begin
                        n.date = bcd_inc(t.date);
                    end
                end else begin
                    n.hr = bcd_inc(t.hr);
                end
            end else begin
                n.min = bcd_inc(t.min);
            end
        end else begin
            n.sec = bcd_inc(t.sec);
        end
        return n;
    endfunction

    // Store one written byte into a time set, clearing unused bits
    function automatic time_t put_field(input time_t t, input fld_e f, input logic [7:0] v);
        time_t n;
        n = t;
        case (f)
            F_SEC:   n.sec  = {1'b0, v[6:0]};
            F_MIN:   n.min  = {1'b0, v[6:0]};
            F_HOUR:  n.hr   = {2'b0, v[5:0]};
            F_DOW:   n.dow  = {5'b0, v[2:0]};
            F_DATE:  n.date = {2'b0, v[5:0]};
            F_MON:   n.mon  = {3'b0, v[4:0]};
            F_YEAR:  n.yr   = v;
            default: n = t;
        endcase
        return n;
    endfunction

    // Form the byte a read returns for one field
    function automatic logic [7:0] get_field(input time_t t, input fld_e f, input logic stop,
                                             input logic ft, input logic hold, input logic frz);
        case (f)
            F_CTL:   return {hold, frz, 6'b0};
            F_SEC:   return {stop, t.sec[6:0]};
            F_MIN:   return {1'b0, t.min[6:0]};
            F_HOUR:  return {2'b0, t.hr[5:0]};
            F_DOW:   return {1'b0, ft, 3'b0, t.dow[2:0]};
            F_DATE:  return {2'b0, t.date[5:0]};
            F_MON:   return {3'b0, t.mon[4:0]};
            default: return t.yr;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bus_ctl.sv
module rtc_bus_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_stb,
    output logic rd_en
);
    logic wr_act;
    logic wr_act_q;

    assign wr_act = !ce_n && !we_n;
    // single strobe when the later of the two enables goes active
    assign wr_stb = wr_act && !wr_act_q;
    assign rd_en  = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (rst) wr_act_q <= 1'b0;
        else     wr_act_q <= wr_act;
    end
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  load,
    input  time_t load_val,
    output time_t cur
);
    always_ff @(posedge clk) begin
        if (rst)       cur <= RESET_TIME;
        else if (load) cur <= load_val;
        else if (adv)  cur <= advance(cur);
    end
endmodule

// File: rtl/bcd_rtc_mem.sv
module bcd_rtc_mem import rtc_pkg::*; #(
    parameter int ADDR_W = 13,
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              sqw
);
    localparam int FLD_W = 3;

    logic wr_stb, rd_en;
    logic clk_sel, clk_wr, ctl_wr, tf_wr, ram_we;
    fld_e fld;
    logic [7:0] ram_q;

    rtc_bus_ctl u_bus (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wr_stb(wr_stb), .rd_en(rd_en)
    );

    assign clk_sel = &addr[ADDR_W-1:FLD_W];
    assign fld     = fld_e'(addr[FLD_W-1:0]);
    assign clk_wr  = wr_stb && clk_sel;
    assign ctl_wr  = clk_wr && (fld == F_CTL);
    assign tf_wr   = clk_wr && (fld != F_CTL);
    assign ram_we  = wr_stb && !clk_sel;

    rtc_ram #(.AW(RAM_AW), .DW(8)) u_ram (
        .clk(clk), .we(ram_we), .addr(addr[RAM_AW-1:0]), .wdata(din), .rdata(ram_q)
    );

    logic  stop_q, ft_q, w_q, r_q, sqw_q;
    time_t cur, stage_q, snap_q, load_val, vis;
    logic  load, adv;

    always_comb begin
        load     = 1'b0;
        load_val = cur;
        if (tf_wr && !w_q) begin
            load     = 1'b1;
            load_val = put_field(cur, fld, din);
        end else if (ctl_wr && w_q && !din[7]) begin
            load     = 1'b1;
            load_val = stage_q;
        end
    end

    assign adv = tick_1hz && !stop_q && !w_q;

    rtc_calendar u_cal (
        .clk(clk), .rst(rst), .adv(adv), .load(load), .load_val(load_val), .cur(cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q  <= 1'b0;
            ft_q    <= 1'b0;
            w_q     <= 1'b0;
            r_q     <= 1'b0;
            sqw_q   <= 1'b0;
            stage_q <= RESET_TIME;
            snap_q  <= RESET_TIME;
        end else begin
            if (clk_wr && fld == F_SEC) stop_q <= din[7];
            if (clk_wr && fld == F_DOW) ft_q   <= din[6];
            if (ctl_wr) begin
                w_q <= din[7];
                r_q <= din[6];
                if (din[7] && !w_q) stage_q <= cur;
                if (din[6] && !r_q) snap_q  <= cur;
            end
            if (tf_wr && w_q) stage_q <= put_field(stage_q, fld, din);
            if (tick_1hz && !stop_q && ft_q) sqw_q <= !sqw_q;
        end
    end

    // read path: freeze copy first, then staged copy, then live counters
    logic       sel_q, oe_q;
    logic [7:0] cbyte_q;

    assign vis = r_q ? snap_q : (w_q ? stage_q : cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            cbyte_q <= 8'h00;
            oe_q    <= 1'b0;
        end else begin
            sel_q   <= clk_sel;
            cbyte_q <= get_field(vis, fld, stop_q, ft_q, w_q, r_q);
            oe_q    <= rd_en;
        end
    end

    assign dq_out = sel_q ? cbyte_q : ram_q;
    assign dq_oe  = oe_q;
    assign sqw    = sqw_q;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker import rtc_pkg::*; (
    input logic  clk,
    input logic  rst,
    input logic  tick_1hz,
    input logic  we_n,
    input logic  wr_stb,
    input logic  stop_q,
    input logic  w_q,
    input logic  r_q,
    input time_t cur,
    input time_t snap_q,
    input logic  dq_oe,
    input logic  sqw
);
    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R4
    hold_freezes_counters_chk: assert property (@(posedge clk) disable iff (rst)
        (w_q && !wr_stb) |=> $stable(cur));

    // R8
    stop_blocks_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_q && tick_1hz && !wr_stb) |=> $stable(cur));

    // R9
    snapshot_held_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q && !wr_stb) |=> $stable(snap_q));

    // R11
    sqw_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_1hz |=> $stable(sqw));

    // R12
    no_drive_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> !dq_oe);
endmodule

bind bcd_rtc_mem rtc_checker u_chk (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .we_n(we_n), .wr_stb(wr_stb),
    .stop_q(stop_q), .w_q(w_q), .r_q(r_q), .cur(cur), .snap_q(snap_q),
    .dq_oe(dq_oe), .sqw(sqw)
);

// File: tb/bcd_rtc_mem_test.sv
module bcd_rtc_mem_test;
    localparam int AW = 13;
    localparam logic [AW-1:0] A_CTL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
                              A_HR  = 13'h1FFB, A_DOW = 13'h1FFC, A_DATE = 13'h1FFD,
                              A_MON = 13'h1FFE, A_YR = 13'h1FFF;

    logic clk = 1'b0, rst = 1'b1, tick_1hz = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = 8'h00, dq_out;
    logic dq_oe, sqw;

    int checks = 0, fails = 0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #5 clk = !clk;

    bcd_rtc_mem uut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe), .sqw(sqw)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one expected byte per driven read
    always @(negedge clk) begin
        if (!rst && dq_oe) begin
            checks++;
            if (q_exp.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected drive act=%02h exp=none", dq_out);
            end else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (dq_out !== e) begin
                    fails++;
                    $display("FAIL %s act=%02h exp=%02h", t, dq_out, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] y, mo, d, w, h, mi, s);
        bus_write(A_CTL, 8'h80);
        bus_write(A_YR, y);
        bus_write(A_MON, mo);
        bus_write(A_DATE, d);
        bus_write(A_DOW, w);
        bus_write(A_HR, h);
        bus_write(A_MIN, mi);
        bus_write(A_SEC, s);
        bus_write(A_CTL, 8'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=hung exp=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk({7'b0, dq_oe}, 8'h00, "R1 dq_oe");
        chk({7'b0, sqw}, 8'h00, "R1 sqw");
        bus_read(A_CTL, 8'h00, "R1 ctl");
        bus_read(A_SEC, 8'h00, "R1 sec");
        bus_read(A_HR, 8'h00, "R1 hour");
        bus_read(A_DOW, 8'h01, "R1 dow");
        bus_read(A_DATE, 8'h01, "R1 date");
        bus_read(A_MON, 8'h01, "R1 month");
        bus_read(A_YR, 8'h00, "R1 year");

        // R2 RAM and aliasing of the lower space
        bus_write(13'h0010, 8'hA5);
        bus_write(13'h1FF7, 8'h3C);
        bus_read(13'h0010, 8'hA5, "R2 ram low");
        bus_read(13'h1FF7, 8'h3C, "R2 ram top");
        bus_read(13'h03F7, 8'h3C, "R2 ram alias");

        // R3 write taken once at the later enable edge
        @(negedge clk);
        addr = 13'h0020; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); din = 8'h22;
        @(negedge clk); din = 8'h33;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        addr = 13'h0021; din = 8'h44; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); din = 8'h55; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        bus_read(13'h0020, 8'h11, "R3 held write");
        bus_read(13'h0021, 8'h55, "R3 second strobe");

        // R4 load via hold bit, R5 carry, R6 leap, R7 dow wrap
        set_time(8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
        bus_read(A_SEC, 8'h58, "R4 loaded sec");
        bus_read(A_DOW, 8'h07, "R4 loaded dow");
        tick();
        bus_read(A_SEC, 8'h59, "R5 sec step");
        tick();
        bus_read(A_SEC, 8'h00, "R5 sec wrap");
        bus_read(A_MIN, 8'h00, "R5 min wrap");
        bus_read(A_HR, 8'h00, "R5 hour wrap");
        bus_read(A_DOW, 8'h01, "R7 dow wrap");
        bus_read(A_DATE, 8'h29, "R6 leap feb 29");
        bus_read(A_MON, 8'h02, "R6 still feb");

        set_time(8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
        tick();
        bus_read(A_DATE, 8'h01, "R6 leap end date");
        bus_read(A_MON, 8'h03, "R6 leap end month");
        bus_read(A_DOW, 8'h04, "R7 dow step");

        set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        tick();
        bus_read(A_DATE, 8'h01, "R6 common feb date");
        bus_read(A_MON, 8'h03, "R6 common feb month");

        set_time(8'h24, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
        tick();
        bus_read(A_DATE, 8'h01, "R6 30-day date");
        bus_read(A_MON, 8'h05, "R6 30-day month");

        set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        tick();
        bus_read(A_YR, 8'h00, "R5 year wrap");
        bus_read(A_MON, 8'h01, "R5 month wrap");
        bus_read(A_DATE, 8'h01, "R6 dec end");
        bus_read(A_DOW, 8'h06, "R7 dow");

        // R8 stop bit
        bus_write(A_SEC, 8'h80);
        tick();
        tick();
        bus_read(A_SEC, 8'h80, "R8 stopped");
        bus_write(A_SEC, 8'h00);
        tick();
        bus_read(A_SEC, 8'h01, "R8 restarted");

        // R9 freeze snapshot while counting continues
        bus_write(A_CTL, 8'h40);
        tick();
        tick();
        bus_read(A_SEC, 8'h01, "R9 frozen sec");
        bus_read(A_CTL, 8'h40, "R9 ctl readback");
        bus_write(A_CTL, 8'h00);
        bus_read(A_SEC, 8'h03, "R9 live again");

        // R4 hold: ticks lost, staged value visible, loaded on release
        bus_write(A_CTL, 8'h80);
        tick();
        bus_read(A_SEC, 8'h03, "R4 held sec");
        bus_write(A_SEC, 8'h30);
        bus_read(A_SEC, 8'h30, "R4 staged sec");
        bus_read(A_CTL, 8'h80, "R4 ctl readback");
        bus_write(A_CTL, 8'h00);
        bus_read(A_SEC, 8'h30, "R4 released sec");
        tick();
        bus_read(A_SEC, 8'h31, "R4 counting again");

        // R10 unused bits
        bus_write(A_MON, 8'hE5);
        bus_read(A_MON, 8'h05, "R10 month mask");
        bus_write(A_CTL, 8'h3F);
        bus_read(A_CTL, 8'h00, "R10 ctl mask");
        bus_write(A_HR, 8'hD2);
        bus_read(A_HR, 8'h12, "R10 hour mask");

        // R11 test square wave
        bus_write(A_DOW, 8'h41);
        bus_read(A_DOW, 8'h41, "R11 test bit readback");
        chk({7'b0, sqw}, 8'h00, "R11 sqw idle");
        tick();
        chk({7'b0, sqw}, 8'h01, "R11 sqw first toggle");
        tick();
        chk({7'b0, sqw}, 8'h00, "R11 sqw second toggle");
        bus_write(A_SEC, 8'hB3);
        tick();
        chk({7'b0, sqw}, 8'h00, "R11 sqw stopped");
        bus_read(A_SEC, 8'hB3, "R8 stop readback");

        // R12 output gating
        @(negedge clk);
        addr = A_CTL; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk({7'b0, dq_oe}, 8'h00, "R12 oe high");
        addr = 13'h0030; din = 8'h77; oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        chk({7'b0, dq_oe}, 8'h00, "R12 write low");
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        bus_read(13'h0030, 8'h77, "R12 read after gated write");

        repeat (4) @(negedge clk);
        if (q_exp.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R12 missing reads act=%0d exp=0", q_exp.size());
        end
        summary();
    end
endmodule